// File: doc/BRIEF.md
# Dual-Read General-Purpose Register File with Pair Access

This block is the working register store of an 8-bit processor datapath. It holds thirty-two byte-wide registers. Two read ports deliver operands combinationally, and a single write port stores a result on the rising clock edge. Each read port can deliver either one register or an aligned register pair as a 16-bit value. The write port takes either a byte result or a 16-bit result that fills an aligned pair.

A pair is always formed by an even-numbered register, which holds the low byte, and the odd register just above it, which holds the high byte. In pair mode the least significant bit of an index has no effect. One width select applies to both read ports. A separate width select governs the write. The ALU and the instruction decode drive these controls from outside the block.

Reads have no write-to-read bypass. A value written at a clock edge appears on the read ports only after that edge.

Top module: `gpr_pair_file`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), every register clears to 0x00. After release, every register reads 0x00 until it is written.
- R2: A byte write (`wr_en`=1, `wr_wide`=0) stores `wr_data[7:0]` in register `wr_idx`. The partner register of that pair and all other registers keep their values. The new value is readable from the cycle after the clock edge.
- R3: A pair write (`wr_en`=1, `wr_wide`=1) stores `wr_data[7:0]` in register `{wr_idx[4:1],0}` and `wr_data[15:8]` in register `{wr_idx[4:1],1}`. Bit 0 of `wr_idx` is ignored.
- R4: With `rd_wide`=0, each operand equals `{8'h00, reg[idx]}` for that port's index.
- R5: With `rd_wide`=1, each operand equals `{reg[{idx[4:1],1}], reg[{idx[4:1],0}]}`. Bit 0 of the read index is ignored.
- R6: The two read ports are independent. Port A and port B return values for different indices in the same cycle.
- R7: A read of a register that is being written in the same cycle returns the value held before the edge, because there is no bypass.
- R8: With `wr_en`=0, no register changes, whatever the values of `wr_idx`, `wr_data` and `wr_wide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Register index for operand A |
| rd_b_idx | input | 5 | Register index for operand B |
| rd_wide | input | 1 | 0: byte reads, 1: pair reads (both ports) |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 16 | Write data; only bits 7:0 are used for byte writes |
| wr_wide | input | 1 | 0: byte write, 1: pair write |
| wr_en | input | 1 | Write enable |
| op_a | output | 16 | Operand A |
| op_b | output | 16 | Operand B |

## Verification
A read and a write can fall in the same cycle and address the same register. They can also overlap partly, for example a byte read of one half of a pair that is being written, or a pair read that covers a byte being written. The random stimulus steers the write index onto a read index in about one cycle in four, in all four width combinations. Directed cases add the same overlap, and each of them also applies an odd index in pair mode. The bench compares the combinational operands, sampled before the edge, with a model that still holds the previous contents. It then commits the write to the model, so a bypass or a late or misplaced write shows up in the following cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    parameter int GPR_NREGS = 32;
    parameter int GPR_DW    = 8;

    typedef enum logic {
        GPR_W_BYTE = 1'b0,
        GPR_W_PAIR = 1'b1
    } gpr_width_e;
endpackage

// File: rtl/gpr_wr_dec.sv
module gpr_wr_dec
    import gpr_pkg::*;
#(
    parameter int NREGS = GPR_NREGS,
    parameter int DW    = GPR_DW,
    localparam int AW   = $clog2(NREGS),
    localparam int PW   = 2 * DW
) (
    input  logic                       wr_en,
    input  logic                       wr_wide,
    input  logic [AW-1:0]              wr_idx,
    input  logic [PW-1:0]              wr_data,
    output logic [NREGS-1:0]           we,
    output logic [NREGS-1:0][DW-1:0]   wd
);
    for (genvar i = 0; i < NREGS; i++) begin : g_slot
        localparam logic [AW-1:0] SLOT = AW'(i);
        logic pair_hit;
        logic byte_hit;
        logic is_pair;

        always_comb begin
            is_pair  = (gpr_width_e'(wr_wide) == GPR_W_PAIR);
            pair_hit = (wr_idx[AW-1:1] == SLOT[AW-1:1]);
            byte_hit = (wr_idx == SLOT);
            we[i]    = wr_en & (is_pair ? pair_hit : byte_hit);
            wd[i]    = (is_pair && SLOT[0]) ? wr_data[PW-1:DW] : wr_data[DW-1:0];
        end
    end
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
#(
    parameter int NREGS = GPR_NREGS,
    parameter int DW    = GPR_DW,
    localparam int AW   = $clog2(NREGS),
    localparam int PW   = 2 * DW
) (
    input  logic [NREGS-1:0][DW-1:0] regs,
    input  logic [AW-1:0]            idx,
    input  logic                     wide,
    output logic [PW-1:0]            operand
);
    logic [AW-1:0] lo_idx;
    logic [AW-1:0] hi_idx;

    always_comb begin
        lo_idx = {idx[AW-1:1], 1'b0};
        hi_idx = {idx[AW-1:1], 1'b1};
        if (gpr_width_e'(wide) == GPR_W_PAIR) begin
            operand = {regs[hi_idx], regs[lo_idx]};
        end else begin
            operand = {{DW{1'b0}}, regs[idx]};
        end
    end
endmodule

// File: rtl/gpr_pair_file.sv
module gpr_pair_file
    import gpr_pkg::*;
#(
    parameter int NREGS = GPR_NREGS,
    parameter int DW    = GPR_DW,
    localparam int AW   = $clog2(NREGS),
    localparam int PW   = 2 * DW,
    localparam int NRD  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic          rd_wide,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_data,
    input  logic          wr_wide,
    input  logic          wr_en,
    output logic [PW-1:0] op_a,
    output logic [PW-1:0] op_b
);
    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] regs;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [NREGS-1:0]         slot_we;
    logic [NREGS-1:0][DW-1:0] slot_wd;

    gpr_wr_dec #(.NREGS(NREGS), .DW(DW)) i_wr_dec (
        .wr_en   (wr_en),
        .wr_wide (wr_wide),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .we      (slot_we),
        .wd      (slot_wd)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREGS; i++) begin
            if (slot_we[i]) begin
                state_d.regs[i] = slot_wd[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    logic [NRD-1:0][AW-1:0] rd_idx;
    logic [NRD-1:0][PW-1:0] rd_op;

    assign rd_idx = {rd_b_idx, rd_a_idx};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        gpr_rd_port #(.NREGS(NREGS), .DW(DW)) i_rd (
            .regs    (state_q.regs),
            .idx     (rd_idx[p]),
            .wide    (rd_wide),
            .operand (rd_op[p])
        );
    end

    assign op_a = rd_op[0];
    assign op_b = rd_op[1];
endmodule

// File: rtl/gpr_pair_file_chk.sv
module gpr_pair_file_chk #(
    parameter int NREGS = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(NREGS),
    localparam int PW   = 2 * DW
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_wide,
    input logic                     wr_en,
    input logic                     wr_wide,
    input logic [AW-1:0]            wr_idx,
    input logic [PW-1:0]            wr_data,
    input logic [PW-1:0]            op_a,
    input logic [PW-1:0]            op_b,
    input logic [NREGS-1:0][DW-1:0] regs
);
    // R1: first cycle out of reset, both ports read zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (op_a == '0 && op_b == '0));

    // R2: byte write lands in the indexed register
    assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |=> regs[$past(wr_idx)] == $past(wr_data[DW-1:0]));

    // R3: pair write fills the aligned even/odd registers
    assert_pair_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide) |=>
            (regs[{$past(wr_idx[AW-1:1]), 1'b0}] == $past(wr_data[DW-1:0]) &&
             regs[{$past(wr_idx[AW-1:1]), 1'b1}] == $past(wr_data[PW-1:DW])));

    // R4: byte reads carry a zero upper byte
    assert_byte_read_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_wide |-> (op_a[PW-1:DW] == '0 && op_b[PW-1:DW] == '0));

    // R8: disabled write leaves storage untouched
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
endmodule

bind gpr_pair_file gpr_pair_file_chk #(.NREGS(NREGS), .DW(DW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_wide (rd_wide),
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .op_a    (op_a),
    .op_b    (op_b),
    .regs    (state_q.regs)
);

// File: tb/test_gpr_pair_file.sv
module test_gpr_pair_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0;
    logic [4:0]  rd_b_idx = '0;
    logic        rd_wide = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        wr_wide = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] op_a;
    logic [15:0] op_b;

    int vectors = 0;
    int misses  = 0;
    logic [7:0] mdl [0:31];

    always #10 clk = ~clk;

    gpr_pair_file i_gpr_pair_file (
        .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_wide(rd_wide), .wr_idx(wr_idx), .wr_data(wr_data), .wr_wide(wr_wide),
        .wr_en(wr_en), .op_a(op_a), .op_b(op_b)
    );

    function automatic logic [15:0] exp_rd(input logic [4:0] idx, input logic wide);
        if (wide) return {mdl[{idx[4:1], 1'b1}], mdl[{idx[4:1], 1'b0}]};
        return {8'h00, mdl[idx]};
    endfunction

    function automatic logic touches(input logic [4:0] ri, input logic rw,
                                     input logic [4:0] wi, input logic ww);
        if (rw || ww) return ri[4:1] == wi[4:1];
        return ri == wi;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle: inputs applied after negedge, operands checked before
    // the posedge against the pre-write model, model updated after the edge.
    task automatic step(input logic [4:0] ra, input logic [4:0] rb, input logic rw,
                        input logic [4:0] wi, input logic [15:0] wd,
                        input logic ww, input logic we, input string tag);
        string ta;
        string tb;
        rd_a_idx = ra; rd_b_idx = rb; rd_wide = rw;
        wr_idx = wi; wr_data = wd; wr_wide = ww; wr_en = we;
        #2;
        ta = rw ? "R5" : "R4";
        if (we && touches(ra, rw, wi, ww)) ta = "R7";
        tb = {"R6/", rw ? "R5" : "R4"};
        if (we && touches(rb, rw, wi, ww)) tb = "R6/R7";
        if (tag != "") begin
            ta = tag;
            tb = {tag, "/R6"};
        end
        chk({ta, " port A"}, op_a, exp_rd(ra, rw));
        chk({tb, " port B"}, op_b, exp_rd(rb, rw));
        @(posedge clk);
        #1;
        if (we) begin
            if (ww) begin
                mdl[{wi[4:1], 1'b0}] = wd[7:0];
                mdl[{wi[4:1], 1'b1}] = wd[15:8];
            end else begin
                mdl[wi] = wd[7:0];
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers read zero after reset
        for (int k = 0; k < 16; k++) begin
            step(5'(2 * k), 5'(2 * k + 1), 1'b0, 5'd0, 16'h0, 1'b0, 1'b0, "R1");
        end

        // R2: byte write to odd register, partner untouched
        step(5'd0, 5'd0, 1'b0, 5'd5, 16'h77A5, 1'b0, 1'b1, "");
        step(5'd4, 5'd5, 1'b1, 5'd0, 16'h0, 1'b0, 1'b0, "R2");
        step(5'd4, 5'd5, 1'b0, 5'd0, 16'h0, 1'b0, 1'b0, "R2");

        // R3: pair write with odd index, bit 0 ignored
        step(5'd0, 5'd1, 1'b0, 5'd7, 16'hBEEF, 1'b1, 1'b1, "");
        step(5'd6, 5'd7, 1'b0, 5'd0, 16'h0, 1'b0, 1'b0, "R3");
        step(5'd7, 5'd6, 1'b1, 5'd0, 16'h0, 1'b0, 1'b0, "R3");

        // R8: disabled write with live-looking data
        step(5'd6, 5'd5, 1'b0, 5'd6, 16'h1234, 1'b1, 1'b0, "");
        step(5'd6, 5'd7, 1'b1, 5'd0, 16'h0, 1'b0, 1'b0, "R8");
        step(5'd6, 5'd5, 1'b0, 5'd0, 16'h0, 1'b0, 1'b0, "R8");

        // R7: same-cycle overlap, old value on ports, new value next cycle
        step(5'd9, 5'd8, 1'b0, 5'd9, 16'h00C3, 1'b0, 1'b1, "R7");
        step(5'd9, 5'd8, 1'b1, 5'd8, 16'h5A3C, 1'b1, 1'b1, "R7");
        step(5'd9, 5'd8, 1'b1, 5'd0, 16'h0, 1'b0, 1'b0, "R7");

        // R6: extreme indices on both ports
        step(5'd0, 5'd31, 1'b0, 5'd31, 16'h00FE, 1'b0, 1'b1, "");
        step(5'd31, 5'd0, 1'b0, 5'd0, 16'h0, 1'b0, 1'b0, "R6");
        step(5'd30, 5'd1, 1'b1, 5'd0, 16'h0, 1'b0, 1'b0, "R6");

        // Random mix; write index aimed at a read index one cycle in four
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] ra;
            logic [4:0] rb;
            logic [4:0] wi;
            ra = 5'($urandom());
            rb = 5'($urandom());
            wi = (($urandom() % 4) == 0) ? ((($urandom() % 2) == 0) ? ra : rb)
                                         : 5'($urandom());
            step(ra, rb, 1'($urandom()), wi, 16'($urandom()),
                 1'($urandom()), (($urandom() % 5) != 0), "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule